// File: doc/BRIEF.md
# Multiplexed LED Column Scan Timer

This block time-multiplexes an LED dot matrix. It steps a single active column across the array. While a column is lit, the block presents that column's row pattern on the row enables. A fixed blanking interval separates one lit column from the next, so two columns are never on at the same time. The time base is an external one-microsecond tick, which acts as a clock enable. All durations are counted in ticks.

A two-bit geometry code sets the number of rows and the number of columns together. The code adds columns and removes rows in equal steps, so each row bit that is given up becomes one extra column. Row bits above the selected row count are forced off. A geometry change waits for the next frame boundary, so a frame never mixes two shapes. A shutdown input blanks the whole array at once. The column words are held outside the block and are not touched by shutdown. When shutdown is released, the scan restarts cleanly from the first column.

Top module: `matrix_scan_timer`

## Requirements
- R1: The geometry code sets the array shape: 00 = 8 rows x 8 columns, 01 = 7 x 9, 10 = 6 x 10, 11 = 5 x 11. Column bits at or above the column count never assert.
- R2: Each column stays lit for ON_TICKS ticks (default 32). It is followed by GAP_TICKS ticks (default 1) in which col_sel and row_en are both zero. One slot is therefore 33 us, and an 8-column frame is 264 us.
- R3: Columns light in ascending order. col_sel bit i is column i+1. After the last column of the current shape, the scan returns to the first column and repeats.
- R4: row_en bit r is row r+1 and is taken from col_data bit (8*c + r) of the lit column c. Row bits at or above the row count of the shape are forced to 0.
- R5: A column's row pattern is captured as the column lights. Any change to its col_data word during that lit window has no effect until the column's next window.
- R6: frame_start is a one-cycle pulse. It occurs in the first cycle that column 1 is lit, and at no other time.
- R7: The geometry code is sampled only at a frame start. A change in the middle of a frame alters neither the column count nor the row mask until the next frame.
- R8: While shutdown is high, col_sel, row_en and frame_start are all zero. After shutdown falls, column 1 lights on the following clock edge, together with frame_start, using the unchanged column words.
- R9: While rst_n is low, all outputs are zero. After reset the scan begins at column 1 on the first clock edge, with geometry 00 unless a different code is applied.
- R10: Scan timing advances only on cycles with us_tick high. With no ticks, col_sel and row_en hold their values.
- R11: col_sel is always one-hot or all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle time-base tick (clock enable for the scan timing) |
| shutdown | input | 1 | Blanks the array and parks the scan |
| mode | input | 2 | Geometry code |
| col_data | input | 88 | Eleven 8-bit column words; column c occupies bits 8c+7..8c |
| col_sel | output | 11 | One-hot lit column, bit 0 = column 1 |
| row_en | output | 8 | Row enables for the lit column, bit 0 = row 1 |
| frame_start | output | 1 | Pulse marking the start of column 1 |

## Verification
The bench builds the block with ON_TICKS = 3 and GAP_TICKS = 2 and holds the tick high for most of the run. A full 11-column frame then takes 55 cycles, so every geometry, the wrap from last column to first, and mid-frame geometry and data changes all fit in a short run. A gap of two ticks makes it visible if the gap counter ends one tick early or late. The lit time is long enough to change a column word part-way through its own window. Stretches with the tick held low check that timing follows the tick and not the clock.

// File: rtl/matrix_scan_pkg.sv
package matrix_scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_GAP  = 2'd2
  } scan_phase_t;
endpackage

// File: rtl/scan_geometry.sv
module scan_geometry #(
  parameter int ROWS      = 8,
  parameter int BASE_COLS = 8,
  parameter int MODE_W    = 2,
  parameter int COL_W     = 4
) (
  input  logic [MODE_W-1:0] geo,
  output logic [COL_W-1:0]  last_col,
  output logic [ROWS-1:0]   row_mask
);
  // one more column and one fewer row per geometry step
  assign last_col = COL_W'(BASE_COLS - 1) + COL_W'(geo);

  for (genvar r = 0; r < ROWS; r++) begin : g_mask
    assign row_mask[r] = (r < (ROWS - int'(geo)));
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import matrix_scan_pkg::*;
#(
  parameter int MODE_W    = 2,
  parameter int COL_W     = 4,
  parameter int ON_TICKS  = 32,
  parameter int GAP_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              shutdown,
  input  logic [MODE_W-1:0] mode,
  input  logic [COL_W-1:0]  last_col,
  output scan_phase_t       phase_o,
  output logic [COL_W-1:0]  col_o,
  output logic [MODE_W-1:0] geo_o,
  output logic              load_o,
  output logic [COL_W-1:0]  load_col_o,
  output logic [MODE_W-1:0] load_geo_o,
  output logic              start_o
);
  localparam int CNT_MAX = (ON_TICKS > GAP_TICKS) ? ON_TICKS : GAP_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_TICKS - 1);

  scan_phase_t       phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [MODE_W-1:0] geo_q, geo_d;
  logic              start_q;
  logic              load, start;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    col_d   = col_q;
    geo_d   = geo_q;
    load    = 1'b0;
    start   = 1'b0;
    if (shutdown) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      col_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_ON;
          cnt_d   = '0;
          col_d   = '0;
          geo_d   = mode;
          load    = 1'b1;
          start   = 1'b1;
        end
        PH_ON: begin
          if (us_tick) begin
            if (cnt_q == ON_LAST) begin
              phase_d = PH_GAP;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        PH_GAP: begin
          if (us_tick) begin
            if (cnt_q == GAP_LAST) begin
              phase_d = PH_ON;
              cnt_d   = '0;
              load    = 1'b1;
              if (col_q == last_col) begin
                col_d = '0;
                geo_d = mode;
                start = 1'b1;
              end else begin
                col_d = col_q + COL_W'(1);
              end
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      geo_q   <= '0;
      start_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      col_q   <= col_d;
      geo_q   <= geo_d;
      start_q <= start;
    end
  end

  assign phase_o    = phase_q;
  assign col_o      = col_q;
  assign geo_o      = geo_q;
  assign load_o     = load;
  assign load_col_o = col_d;
  assign load_geo_o = geo_d;
  assign start_o    = start_q;
endmodule

// File: rtl/scan_row_latch.sv
module scan_row_latch #(
  parameter int ROWS     = 8,
  parameter int MAX_COLS = 11,
  parameter int COL_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [COL_W-1:0]         load_col,
  input  logic [ROWS-1:0]          mask,
  input  logic [MAX_COLS*ROWS-1:0] col_data,
  output logic [ROWS-1:0]          row_q
);
  logic [ROWS-1:0] picked;

  always_comb begin
    picked = '0;
    for (int c = 0; c < MAX_COLS; c++) begin
      if (load_col == COL_W'(c)) picked = col_data[c*ROWS +: ROWS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (load) begin
      row_q <= picked & mask;
    end
  end
endmodule

// File: rtl/matrix_scan_timer.sv
module matrix_scan_timer
  import matrix_scan_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int BASE_COLS = 8,
  parameter int MODE_W    = 2,
  parameter int ON_TICKS  = 32,
  parameter int GAP_TICKS = 1
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           us_tick,
  input  logic                                           shutdown,
  input  logic [MODE_W-1:0]                              mode,
  input  logic [(BASE_COLS+(1<<MODE_W)-1)*ROWS-1:0]      col_data,
  output logic [BASE_COLS+(1<<MODE_W)-2:0]               col_sel,
  output logic [ROWS-1:0]                                row_en,
  output logic                                           frame_start
);
  localparam int MAX_COLS = BASE_COLS + (1 << MODE_W) - 1;
  localparam int COL_W    = $clog2(MAX_COLS);

  scan_phase_t       phase;
  logic [COL_W-1:0]  cur_col, last_col, load_col;
  logic [MODE_W-1:0] frame_geo, load_geo;
  logic [ROWS-1:0]   load_mask, row_q, unused_mask;
  logic              load, start_q, lit;

  scan_sequencer #(
    .MODE_W(MODE_W), .COL_W(COL_W),
    .ON_TICKS(ON_TICKS), .GAP_TICKS(GAP_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .shutdown(shutdown),
    .mode(mode), .last_col(last_col),
    .phase_o(phase), .col_o(cur_col), .geo_o(frame_geo),
    .load_o(load), .load_col_o(load_col), .load_geo_o(load_geo),
    .start_o(start_q)
  );

  // geometry of the running frame decides the wrap point
  scan_geometry #(
    .ROWS(ROWS), .BASE_COLS(BASE_COLS), .MODE_W(MODE_W), .COL_W(COL_W)
  ) u_geo_cur (
    .geo(frame_geo), .last_col(last_col), .row_mask(unused_mask)
  );

  // geometry about to take effect decides the mask of the captured column
  logic [COL_W-1:0] unused_last;
  scan_geometry #(
    .ROWS(ROWS), .BASE_COLS(BASE_COLS), .MODE_W(MODE_W), .COL_W(COL_W)
  ) u_geo_next (
    .geo(load_geo), .last_col(unused_last), .row_mask(load_mask)
  );

  scan_row_latch #(
    .ROWS(ROWS), .MAX_COLS(MAX_COLS), .COL_W(COL_W)
  ) u_rows (
    .clk(clk), .rst_n(rst_n), .load(load), .load_col(load_col),
    .mask(load_mask), .col_data(col_data), .row_q(row_q)
  );

  assign lit = (phase == PH_ON) && !shutdown;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    assign col_sel[c] = lit && (cur_col == COL_W'(c));
  end

  assign row_en      = lit ? row_q : '0;
  assign frame_start = start_q && !shutdown;
endmodule

// File: rtl/matrix_scan_timer_chk.sv
module matrix_scan_timer_chk #(
  parameter int ROWS      = 8,
  parameter int BASE_COLS = 8,
  parameter int MODE_W    = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               us_tick,
  input logic                               shutdown,
  input logic [BASE_COLS+(1<<MODE_W)-2:0]   col_sel,
  input logic [ROWS-1:0]                    row_en,
  input logic                               frame_start,
  input logic [MODE_W-1:0]                  geo
);
  localparam int MAX_COLS = BASE_COLS + (1 << MODE_W) - 1;

  logic [ROWS-1:0]     rows_ok;
  logic [MAX_COLS-1:0] cols_ok;

  always_comb begin
    for (int r = 0; r < ROWS; r++) rows_ok[r] = (r + int'(geo)) < ROWS;
    for (int c = 0; c < MAX_COLS; c++) cols_ok[c] = c < (BASE_COLS + int'(geo));
  end

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));

  a_r2_rows_dark_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel == '0) |-> (row_en == '0));

  a_r4_row_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en & ~rows_ok) == '0);

  a_r1_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel & ~cols_ok) == '0);

  a_r6_start_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> col_sel[0]);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r8_blank_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && $past(shutdown)) |-> (col_sel == '0 && row_en == '0 && !frame_start));

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_tick && !shutdown && col_sel != '0) |=>
      (shutdown || ($stable(col_sel) && $stable(row_en))));
endmodule

bind matrix_scan_timer matrix_scan_timer_chk #(
  .ROWS(ROWS), .BASE_COLS(BASE_COLS), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .shutdown(shutdown),
  .col_sel(col_sel), .row_en(row_en), .frame_start(frame_start),
  .geo(frame_geo)
);

// File: tb/matrix_scan_timer_test.sv
module matrix_scan_timer_test;
  localparam int ON   = 3;
  localparam int GAP  = 2;
  localparam int SLOT = ON + GAP;
  localparam int NC   = 11;

  logic         clk;
  logic         rst_n;
  logic         us_tick;
  logic         shutdown;
  logic [1:0]   mode;
  logic [87:0]  col_data;
  logic [10:0]  col_sel;
  logic [7:0]   row_en;
  logic         frame_start;
  logic [7:0]   dat [NC];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // mode, column count, row mask
  localparam logic [13:0] SHAPES [4] = '{
    {2'd0, 4'd8,  8'hFF},
    {2'd1, 4'd9,  8'h7F},
    {2'd2, 4'd10, 8'h3F},
    {2'd3, 4'd11, 8'h1F}
  };

  matrix_scan_timer #(.ON_TICKS(ON), .GAP_TICKS(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .shutdown(shutdown),
    .mode(mode), .col_data(col_data), .col_sel(col_sel),
    .row_en(row_en), .frame_start(frame_start)
  );

  always_comb for (int c = 0; c < NC; c++) col_data[c*8 +: 8] = dat[c];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic blank(string tag);
    chk({tag, " col"}, 32'(col_sel), 0);
    chk({tag, " row"}, 32'(row_en), 0);
    chk({tag, " fs"},  32'(frame_start), 0);
  endtask

  task automatic restart(logic [1:0] m);
    mode = m;
    shutdown = 1'b1;
    @(negedge clk);
    blank("R8 shutdown");
    shutdown = 1'b0;
    @(negedge clk);
  endtask

  // walks one frame from its first cycle; leaves at the next frame's first cycle
  task automatic run_frame(int ncols, logic [7:0] mask, int chg_k, logic [1:0] chg_mode,
                           int poke_k, int poke_col, logic [7:0] poke_val);
    logic [7:0] lat = '0;
    for (int k = 0; k < ncols * SLOT; k++) begin
      int s = k / SLOT;
      int p = k % SLOT;
      if (p == 0) lat = dat[s] & mask;
      if (p < ON) begin
        chk("R1 R3 col", 32'(col_sel), 32'(1) << s);
        chk("R4 R5 row", 32'(row_en), 32'(lat));
      end else begin
        chk("R2 gap col", 32'(col_sel), 0);
        chk("R2 gap row", 32'(row_en), 0);
      end
      chk("R6 frame_start", 32'(frame_start), (k == 0) ? 1 : 0);
      if (k == chg_k) mode = chg_mode;
      if (k == poke_k) dat[poke_col] = poke_val;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; us_tick = 1'b1; shutdown = 1'b0; mode = 2'd0;
    for (int c = 0; c < NC; c++) dat[c] = 8'(c * 29 + 8'hA7);
    repeat (3) @(negedge clk);
    blank("R9 reset");

    // R9: scan starts at column 1 right after reset, geometry 00
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(8, 8'hFF, -1, 2'd0, -1, 0, 8'h00);

    // R1 R3: every geometry, two frames each to cover the wrap
    for (int i = 0; i < 4; i++) begin
      restart(SHAPES[i][13:12]);
      run_frame(int'(SHAPES[i][11:8]), SHAPES[i][7:0], -1, 2'd0, -1, 0, 8'h00);
      run_frame(int'(SHAPES[i][11:8]), SHAPES[i][7:0], -1, 2'd0, -1, 0, 8'h00);
    end

    // R7 geometry change mid-frame; R5 data change inside column 3's window
    restart(2'd0);
    run_frame(8, 8'hFF, 7, 2'd3, SLOT * 2 + 1, 2, 8'hE3);
    run_frame(11, 8'h1F, -1, 2'd0, -1, 0, 8'h00);

    // R10: no ticks, outputs hold
    restart(2'd0);
    us_tick = 1'b0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk("R10 hold col", 32'(col_sel), 1);
      chk("R10 hold row", 32'(row_en), 32'(dat[0]));
      chk("R10 fs once", 32'(frame_start), 0);
    end
    us_tick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 still lit", 32'(col_sel), 1);
    @(negedge clk);
    chk("R10 gap reached", 32'(col_sel), 0);

    // R8: shutdown mid-frame, then clean restart with retained data
    repeat (4) @(negedge clk);
    shutdown = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      blank("R8 mid-frame");
    end
    shutdown = 1'b0;
    @(negedge clk);
    run_frame(8, 8'hFF, -1, 2'd0, -1, 0, 8'h00);

    // R9: reset during scan
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    blank("R9 reset mid-scan");
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(8, 8'hFF, -1, 2'd0, -1, 0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule